// File: doc/BRIEF.md
# Debug Break Entry and Return Sequencer

This block sits beside the status register of a small soft processor and performs the bookkeeping of a debug break. A break begins when a break instruction retires (software request) or when the debug port raises a hardware request. Within that same cycle the block:

- offers an updated status word to the core;
- writes the return address into the reserved break-address register;
- redirects fetch to a fixed break vector.

At the following clock edge it keeps the untouched status word in its own saved-status register.

A return-from-break request is handled in one cycle. The block offers the saved-status word back to the core as the new status, and it redirects fetch to the address the core reads from the reserved break-address register. The memory-management and memory-protection options are elaboration parameters, and they decide whether the user-mode and exception-handling bits take part in break entry. Non-maskable interrupts are not gated by this block. Only the maskable-interrupt enable is cleared, so a non-maskable interrupt can still be taken during a break.

Top module: `brk_ctl`

## Requirements
- R1: After reset the saved-status register reads 0. With no request present, `redir`, `st_we` and `ba_we` are all 0.
- R2: A software request, a hardware request, or both together cause a single entry. In that cycle `redir` is 1 and `redir_pc` equals parameter `BRK_VEC`.
- R3: At the clock edge that ends an entry cycle, the saved-status register takes the `st_cur` value presented in that cycle, with no field modified.
- R4: On entry, `st_we` is 1 and bit 0 of `st_nxt` (maskable-interrupt enable) is 0.
- R5: On entry, `ba_we` is 1 and `ba_wdata` equals `next_pc`.
- R6: On entry, bit 1 of `st_nxt` (user mode) is 0 when `HAS_MMU` or `HAS_MPU` is 1. Otherwise it keeps the bit 1 value of `st_cur`.
- R7: On entry, bit 2 of `st_nxt` (exception handling) is 1 when `HAS_MMU` is 1. Otherwise it keeps the bit 2 value of `st_cur`.
- R8: On entry, bits 21:16 of `st_nxt` (previous register set) equal bits 15:10 of `st_cur` (current register set), and bits 15:10 of `st_nxt` are 0. All bits not named in R4, R6, R7 and R8 equal `st_cur`.
- R9: A return request without a break request makes `st_we` 1, `st_nxt` equal to the saved-status register, `redir` 1, `redir_pc` equal to `ba_rdata`, and `ba_we` 0.
- R10: A break request in the same cycle as a return request is handled as an entry only (R2 to R8).
- R11: A return cycle, or a cycle with no request, leaves the saved-status register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_brk | input | 1 | Break instruction retiring |
| hw_brk | input | 1 | Break request from the debug port |
| brk_ret | input | 1 | Return-from-break instruction retiring |
| st_cur | input | 32 | Current status register value |
| next_pc | input | AW | Address of the instruction after the break |
| ba_rdata | input | AW | Value of the reserved break-address register |
| st_we | output | 1 | Status write enable |
| st_nxt | output | 32 | Status value to write |
| st_saved | output | 32 | Saved-status register |
| ba_we | output | 1 | Write enable for the reserved break-address register |
| ba_wdata | output | AW | Value written to the break-address register |
| redir | output | 1 | Fetch redirect strobe |
| redir_pc | output | AW | Fetch redirect target |

## Verification
The bench builds two instances that receive identical stimulus. One has only the protection unit enabled, so the user bit is cleared on entry while the exception-handling bit passes through. The other has only the management unit enabled, so both bits are forced. Between them the bench shows each option acting alone on the fields it controls. Each instance has its own break vector, so a redirect that reaches the wrong target shows up in the comparison.

// File: rtl/brk_ctl.sv
module brk_ctl #(
  parameter int          AW      = 32,
  parameter logic [AW-1:0] BRK_VEC = 32'h0000_0020,
  parameter bit          HAS_MMU = 1'b0,
  parameter bit          HAS_MPU = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_brk,
  input  logic          hw_brk,
  input  logic          brk_ret,
  input  logic [31:0]   st_cur,
  input  logic [AW-1:0] next_pc,
  input  logic [AW-1:0] ba_rdata,
  output logic          st_we,
  output logic [31:0]   st_nxt,
  output logic [31:0]   st_saved,
  output logic          ba_we,
  output logic [AW-1:0] ba_wdata,
  output logic          redir,
  output logic [AW-1:0] redir_pc
);
  localparam int BIT_PIE = 0;
  localparam int BIT_U   = 1;
  localparam int BIT_EH  = 2;
  localparam int RS_W    = 6;
  localparam int CRS_LO  = 10;
  localparam int PRS_LO  = 16;

  logic        enter, leave;
  logic [31:0] st_enter;

  assign enter = sw_brk | hw_brk;
  assign leave = brk_ret & ~enter;

  always_comb begin
    st_enter = st_cur;
    st_enter[BIT_PIE] = 1'b0;
    if (HAS_MMU || HAS_MPU) st_enter[BIT_U] = 1'b0;
    if (HAS_MMU) st_enter[BIT_EH] = 1'b1;
    st_enter[PRS_LO +: RS_W] = st_cur[CRS_LO +: RS_W];
    st_enter[CRS_LO +: RS_W] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     st_saved <= '0;
    else if (enter) st_saved <= st_cur;
  end

  assign st_we    = enter | leave;
  assign st_nxt   = enter ? st_enter : st_saved;
  assign ba_we    = enter;
  assign ba_wdata = next_pc;
  assign redir    = enter | leave;
  assign redir_pc = enter ? BRK_VEC : ba_rdata;
endmodule

// File: rtl/brk_ctl_chk.sv
module brk_ctl_chk #(
  parameter int          AW      = 32,
  parameter logic [AW-1:0] BRK_VEC = 32'h0000_0020
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sw_brk,
  input logic          hw_brk,
  input logic          brk_ret,
  input logic [31:0]   st_cur,
  input logic [AW-1:0] next_pc,
  input logic [AW-1:0] ba_rdata,
  input logic          st_we,
  input logic [31:0]   st_nxt,
  input logic [31:0]   st_saved,
  input logic          ba_we,
  input logic [AW-1:0] ba_wdata,
  input logic          redir,
  input logic [AW-1:0] redir_pc
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_brk || hw_brk || brk_ret) |-> !redir && !st_we && !ba_we);

  assert_entry_vector_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_brk || hw_brk) |-> redir && redir_pc == BRK_VEC);

  assert_saved_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_brk || hw_brk) |=> st_saved == $past(st_cur));

  assert_pie_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_brk || hw_brk) |-> st_we && !st_nxt[0]);

  assert_ba_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_brk || hw_brk) |-> ba_we && ba_wdata == next_pc);

  assert_rs_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_brk || hw_brk) |-> st_nxt[21:16] == st_cur[15:10] && st_nxt[15:10] == 6'd0);

  assert_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_ret && !sw_brk && !hw_brk) |-> st_we && st_nxt == st_saved && redir
                                        && redir_pc == ba_rdata && !ba_we);

  assert_saved_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_brk || hw_brk) |=> $stable(st_saved));
endmodule

bind brk_ctl brk_ctl_chk #(.AW(AW), .BRK_VEC(BRK_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_brk(sw_brk), .hw_brk(hw_brk), .brk_ret(brk_ret),
  .st_cur(st_cur), .next_pc(next_pc), .ba_rdata(ba_rdata), .st_we(st_we),
  .st_nxt(st_nxt), .st_saved(st_saved), .ba_we(ba_we), .ba_wdata(ba_wdata),
  .redir(redir), .redir_pc(redir_pc)
);

// File: tb/sim_brk_ctl.sv
`timescale 1ns/1ps
module sim_brk_ctl;
  localparam logic [31:0] VEC0 = 32'h0000_0020;
  localparam logic [31:0] VEC1 = 32'h0000_0440;

  typedef struct packed {
    logic        sw, hw, ret;
    logic [31:0] st, npc, ba;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b0, 1'b0, 32'h0003_FC07, 32'h0000_0100, 32'h0000_0000},
    '{1'b0, 1'b0, 1'b1, 32'h0000_0000, 32'h0000_0000, 32'h0000_0104},
    '{1'b0, 1'b1, 1'b0, 32'h0000_1401, 32'h0000_2000, 32'h1111_0000},
    '{1'b1, 1'b1, 1'b0, 32'hA5A5_5A5A, 32'h0000_3004, 32'h2222_0000},
    '{1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_3008},
    '{1'b1, 1'b0, 1'b1, 32'h0000_0002, 32'h0000_4000, 32'h0BAD_0000},
    '{1'b0, 1'b0, 1'b0, 32'h1234_5678, 32'h0000_5000, 32'h0000_5000},
    '{1'b0, 1'b0, 1'b1, 32'h0000_0000, 32'h0000_0000, 32'hDEAD_BEE0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sw_brk = 0, hw_brk = 0, brk_ret = 0;
  logic [31:0] st_cur = 0, next_pc = 0, ba_rdata = 0;

  logic        we0, bw0, rd0, we1, bw1, rd1;
  logic [31:0] sn0, ss0, bd0, rp0, sn1, ss1, bd1, rp1;

  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  brk_ctl #(.AW(32), .BRK_VEC(VEC0), .HAS_MMU(1'b0), .HAS_MPU(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .sw_brk(sw_brk), .hw_brk(hw_brk), .brk_ret(brk_ret),
    .st_cur(st_cur), .next_pc(next_pc), .ba_rdata(ba_rdata), .st_we(we0),
    .st_nxt(sn0), .st_saved(ss0), .ba_we(bw0), .ba_wdata(bd0), .redir(rd0),
    .redir_pc(rp0));

  brk_ctl #(.AW(32), .BRK_VEC(VEC1), .HAS_MMU(1'b1), .HAS_MPU(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .sw_brk(sw_brk), .hw_brk(hw_brk), .brk_ret(brk_ret),
    .st_cur(st_cur), .next_pc(next_pc), .ba_rdata(ba_rdata), .st_we(we1),
    .st_nxt(sn1), .st_saved(ss1), .ba_we(bw1), .ba_wdata(bd1), .redir(rd1),
    .redir_pc(rp1));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_entry(input logic [31:0] s, input bit mmu, input bit mpu);
    logic [31:0] r = s;
    r[0] = 1'b0;
    if (mmu || mpu) r[1] = 1'b0;
    if (mmu) r[2] = 1'b1;
    r[21:16] = s[15:10];
    r[15:10] = 6'd0;
    return r;
  endfunction

  initial begin
    #(4 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] sav;
    repeat (3) @(negedge clk);
    chk("R1 reset saved u0", ss0, 32'h0);
    chk("R1 reset saved u1", ss1, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle strobes u0", {29'd0, we0, bw0, rd0}, 32'h0);
    chk("R1 idle strobes u1", {29'd0, we1, bw1, rd1}, 32'h0);
    sav = 32'h0;

    for (int i = 0; i < NV; i++) begin
      logic entry, leave;
      sw_brk = TBL[i].sw; hw_brk = TBL[i].hw; brk_ret = TBL[i].ret;
      st_cur = TBL[i].st; next_pc = TBL[i].npc; ba_rdata = TBL[i].ba;
      entry = TBL[i].sw | TBL[i].hw;
      leave = TBL[i].ret & ~entry;
      #1;
      if (entry) begin
        chk("R2 redirect u0", {31'd0, rd0}, 32'd1);
        chk("R2 vector u0", rp0, VEC0);
        chk("R2 vector u1", rp1, VEC1);
        chk("R4 st_we u0", {31'd0, we0}, 32'd1);
        chk("R5 ba_we u1", {31'd0, bw1}, 32'd1);
        chk("R5 ba_wdata u0", bd0, TBL[i].npc);
        chk("R6 R8 entry status u0 mpu", sn0, model_entry(TBL[i].st, 1'b0, 1'b1));
        chk("R7 R8 entry status u1 mmu", sn1, model_entry(TBL[i].st, 1'b1, 1'b0));
        if (TBL[i].ret) chk("R10 entry wins u1", sn1, model_entry(TBL[i].st, 1'b1, 1'b0));
      end else if (leave) begin
        chk("R9 st_we u0", {31'd0, we0}, 32'd1);
        chk("R9 restore u0", sn0, sav);
        chk("R9 restore u1", sn1, sav);
        chk("R9 target u1", rp1, TBL[i].ba);
        chk("R9 no ba_we u0", {31'd0, bw0, rd0}, 32'd1);
      end else begin
        chk("R1 idle strobes u0", {29'd0, we0, bw0, rd0}, 32'h0);
      end
      @(negedge clk);
      if (entry) sav = TBL[i].st;
      chk(entry ? "R3 saved u0" : "R11 saved u0", ss0, sav);
      chk(entry ? "R3 saved u1" : "R11 saved u1", ss1, sav);
    end

    sw_brk = 0; hw_brk = 0; brk_ret = 0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset clears saved u0", ss0, 32'h0);
    chk("R1 reset clears saved u1", ss1, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule